// File: doc/BRIEF.md
# Card Host Interrupt and Status Registers

This block holds the interrupt and status state of a memory-card host controller. The command, data and card-detect logic report events on pulse inputs, and the block records them in a raw interrupt status word. A mask and a global interrupt enable decide whether those events reach the single interrupt line. Software reads and clears the state through a small 32-bit register port that takes whole-word accesses only. Clearing works by writing ones.

The block also stores the global control word, in which three reset request bits clear themselves. It keeps a card status word that tracks card presence, and a DMA status word whose software clear covers only its low ten bits. It holds the timeout, block size and byte count settings. A down-counter follows the bytes still to be moved: each reported data beat lowers it, and data-complete is raised when it reaches zero.

The command engine and the DMA engine are not part of this block. They only drive its event inputs.

Top module: `sdhc_irq_regs`

## Requirements
- R1: `irq` is high only when control bit 4 is set and at least one bit of (raw status AND mask) is set. When either condition fails, `irq` is low.
- R2: Reading the masked-status register returns raw AND mask. A write to either the raw register (index 2) or the masked-status register (index 3) clears every raw bit written as 1.
- R3: A `card_insert` pulse sets raw bit 30, clears raw bit 31 and sets status bit 8. A `card_remove` pulse sets raw bit 31, clears raw bit 30 and clears status bit 8. When both pulses arrive in the same cycle, insertion wins.
- R4: A write to control stores the written value with bits 2:0 forced to 0.
- R5: A write to DMA status clears only the bits written as 1 within bits 9:0. Bits 31:10 keep their value. `dma_set` ORs bits into DMA status.
- R6: A write to byte count loads both the byte count and the remaining counter. Each `beat_valid` cycle subtracts `beat_bytes` from the counter, stopping at 0. A beat that leaves the counter at 0 sets raw bit 3. If a load and a beat arrive in the same cycle, the load wins.
- R7: After reset, the registers read as follows: control 0x300, stored status 0x100, timeout 0xFFFFFF40, block size 0x200, byte count 0x200, remaining count 0. Mask, raw status and DMA status are 0.
- R8: A status read adds bit 17 when `data_ready` is high and bit 2 when it is low. Neither bit is stored.
- R9: When a set event and a software clear hit the same bit in one cycle, the bit ends up set. This holds for raw status and for DMA status.
- R10: A write to status clears the stored status bits written as 1. A card event in the same cycle overrides bit 8.
- R11: The register map, by word index, is: 0 control, 1 mask, 2 raw status, 3 masked status, 4 status, 5 DMA status, 6 byte count, 7 block size, 8 timeout, 9 remaining count (read-only). Mask, block size and timeout read back what was written. Any other index reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 4 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_idx` (combinational) |
| ev_set | input | 32 | Raw status set pulses from the command and data logic |
| card_insert | input | 1 | Card inserted event |
| card_remove | input | 1 | Card removed event |
| dma_set | input | 32 | DMA status set pulses |
| beat_valid | input | 1 | A data beat moved in this cycle |
| beat_bytes | input | 8 | Size of the beat in bytes |
| data_ready | input | 1 | Card data is available to read |
| irq | output | 1 | Interrupt line |

## Verification
The hardest case to bring about is a software clear that lands in the same cycle as a hardware set on the same bit. The bench drives a write to the raw register and an event pulse on the same clock edge, then reads back which bits survived. The counter's stop at zero is reached by sweeping load values against beat sizes that do not divide them, so the last beat overshoots. Extra beats after the counter reaches zero are also driven. Every one of the 32 raw bits is walked through set, mask, gate and clear, using the raw and masked clear addresses in turn.

// File: rtl/sdhc_irq_pkg.sv
package sdhc_irq_pkg;
  localparam int DW    = 32;
  localparam int IDX_W = 4;

  localparam logic [IDX_W-1:0] IX_CTRL  = 4'd0;
  localparam logic [IDX_W-1:0] IX_MASK  = 4'd1;
  localparam logic [IDX_W-1:0] IX_RAW   = 4'd2;
  localparam logic [IDX_W-1:0] IX_MSTAT = 4'd3;
  localparam logic [IDX_W-1:0] IX_STAT  = 4'd4;
  localparam logic [IDX_W-1:0] IX_DMA   = 4'd5;
  localparam logic [IDX_W-1:0] IX_BYTES = 4'd6;
  localparam logic [IDX_W-1:0] IX_BLK   = 4'd7;
  localparam logic [IDX_W-1:0] IX_TMO   = 4'd8;
  localparam logic [IDX_W-1:0] IX_REM   = 4'd9;

  localparam logic [DW-1:0] CTRL_RST = 32'h0000_0300;
  localparam logic [DW-1:0] STAT_RST = 32'h0000_0100;
  localparam logic [DW-1:0] TMO_RST  = 32'hFFFF_FF40;
  localparam logic [DW-1:0] BLK_RST  = 32'h0000_0200;

  localparam int BIT_IRQ_EN = 4;
  localparam int BIT_DONE   = 3;
  localparam int BIT_INS    = 30;
  localparam int BIT_OUT    = 31;
  localparam int ST_CARD    = 8;
  localparam int ST_READY   = 17;
  localparam int ST_EMPTY   = 2;
  localparam int CTRL_SC_W  = 3;
  localparam int DMA_CLR_W  = 10;

  // clear-by-one, then set: a set in the same cycle wins
  function automatic logic [DW-1:0] w1c_next(input logic [DW-1:0] cur,
                                             input logic [DW-1:0] clr,
                                             input logic [DW-1:0] set);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/sdhc_raw_bank.sv
module sdhc_raw_bank
  import sdhc_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_we,
  input  logic [DW-1:0] clr_data,
  input  logic [DW-1:0] set_vec,
  input  logic [DW-1:0] knock_vec,
  input  logic          mask_we,
  input  logic [DW-1:0] mask_data,
  input  logic          irq_en,
  output logic [DW-1:0] raw_q,
  output logic [DW-1:0] mask_q,
  output logic          irq
);
  logic [DW-1:0] clr_eff;
  logic [DW-1:0] masked;

  assign clr_eff = (clr_we ? clr_data : '0) | knock_vec;
  assign masked  = raw_q & mask_q;
  assign irq     = irq_en & (|masked);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q <= w1c_next(raw_q, clr_eff, set_vec);
      if (mask_we) mask_q <= mask_data;
    end
  end

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((raw_q & $past(set_vec)) == $past(set_vec)));
  // R2
  sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && set_vec == '0) |=> ((raw_q & $past(clr_data)) == '0));
endmodule

// File: rtl/sdhc_xfer_count.sv
module sdhc_xfer_count #(
  parameter int CW = 32,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          beat,
  input  logic [BW-1:0] beat_bytes,
  output logic [CW-1:0] rem_q,
  output logic          zero_hit
);
  localparam int PAD = CW - BW;

  function automatic logic [CW-1:0] sat_sub(input logic [CW-1:0] a,
                                            input logic [CW-1:0] b);
    return (a > b) ? (a - b) : '0;
  endfunction

  logic [CW-1:0] step;
  logic [CW-1:0] after_beat;

  assign step       = {{PAD{1'b0}}, beat_bytes};
  assign after_beat = sat_sub(rem_q, step);
  assign zero_hit   = beat && !load && (after_beat == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rem_q <= '0;
    else if (load)  rem_q <= load_val;
    else if (beat)  rem_q <= after_beat;
  end

  // R6
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !load) |=> (rem_q <= $past(rem_q)));
  // R6
  zero_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_hit |=> (rem_q == '0));
endmodule

// File: rtl/sdhc_ctrl_regs.sv
module sdhc_ctrl_regs
  import sdhc_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [DW-1:0]    wdata,
  input  logic             ins_ev,
  input  logic             out_ev,
  input  logic [DW-1:0]    dma_set,
  output logic [DW-1:0]    ctrl_q,
  output logic [DW-1:0]    stat_q,
  output logic [DW-1:0]    dma_q,
  output logic [DW-1:0]    bytes_q,
  output logic [DW-1:0]    blk_q,
  output logic [DW-1:0]    tmo_q
);
  localparam logic [DW-1:0] SC_MASK  = DW'((1 << CTRL_SC_W) - 1);
  localparam logic [DW-1:0] DMA_WIN  = DW'((1 << DMA_CLR_W) - 1);

  logic [DW-1:0] stat_clr;
  logic [DW-1:0] dma_clr;
  logic [DW-1:0] stat_w1c;

  assign stat_clr = (we && idx == IX_STAT) ? wdata : '0;
  assign dma_clr  = (we && idx == IX_DMA) ? (wdata & DMA_WIN) : '0;
  assign stat_w1c = stat_q & ~stat_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= CTRL_RST;
      stat_q  <= STAT_RST;
      dma_q   <= '0;
      bytes_q <= BLK_RST;
      blk_q   <= BLK_RST;
      tmo_q   <= TMO_RST;
    end else begin
      if (we && idx == IX_CTRL)  ctrl_q  <= wdata & ~SC_MASK;
      if (we && idx == IX_BYTES) bytes_q <= wdata;
      if (we && idx == IX_BLK)   blk_q   <= wdata;
      if (we && idx == IX_TMO)   tmo_q   <= wdata;
      dma_q <= w1c_next(dma_q, dma_clr, dma_set);
      stat_q <= stat_w1c;
      if (ins_ev)      stat_q[ST_CARD] <= 1'b1;
      else if (out_ev) stat_q[ST_CARD] <= 1'b0;
    end
  end

  // R4
  ctrl_selfclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && idx == IX_CTRL) |=> (ctrl_q[CTRL_SC_W-1:0] == '0));
  // R5
  dma_high_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && idx == IX_DMA && dma_set == '0) |=> $stable(dma_q[DW-1:DMA_CLR_W]));
  // R3
  card_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_ev |=> stat_q[ST_CARD]);
endmodule

// File: rtl/sdhc_irq_regs.sv
module sdhc_irq_regs
  import sdhc_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [IDX_W-1:0] reg_idx,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic [DW-1:0]    ev_set,
  input  logic             card_insert,
  input  logic             card_remove,
  input  logic [DW-1:0]    dma_set,
  input  logic             beat_valid,
  input  logic [7:0]       beat_bytes,
  input  logic             data_ready,
  output logic             irq
);
  logic          ins_ev, out_ev, zero_hit;
  logic [DW-1:0] set_vec, knock_vec;
  logic [DW-1:0] raw_q, mask_q, ctrl_q, stat_q, dma_q, bytes_q, blk_q, tmo_q, rem_q;
  logic [DW-1:0] stat_view;

  // insertion has priority when both card events arrive together
  assign ins_ev = card_insert;
  assign out_ev = card_remove & ~card_insert;

  always_comb begin
    set_vec   = ev_set;
    knock_vec = '0;
    set_vec[BIT_DONE] = ev_set[BIT_DONE] | zero_hit;
    if (ins_ev) begin
      set_vec[BIT_INS]   = 1'b1;
      knock_vec[BIT_OUT] = 1'b1;
    end else if (out_ev) begin
      set_vec[BIT_OUT]   = 1'b1;
      knock_vec[BIT_INS] = 1'b1;
    end
  end

  sdhc_raw_bank u_raw (
    .clk(clk), .rst_n(rst_n),
    .clr_we(reg_we && (reg_idx == IX_RAW || reg_idx == IX_MSTAT)),
    .clr_data(reg_wdata), .set_vec(set_vec), .knock_vec(knock_vec),
    .mask_we(reg_we && reg_idx == IX_MASK), .mask_data(reg_wdata),
    .irq_en(ctrl_q[BIT_IRQ_EN]), .raw_q(raw_q), .mask_q(mask_q), .irq(irq)
  );

  sdhc_xfer_count #(.CW(DW), .BW(8)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .load(reg_we && reg_idx == IX_BYTES), .load_val(reg_wdata),
    .beat(beat_valid), .beat_bytes(beat_bytes),
    .rem_q(rem_q), .zero_hit(zero_hit)
  );

  sdhc_ctrl_regs u_ctl (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .idx(reg_idx), .wdata(reg_wdata),
    .ins_ev(ins_ev), .out_ev(out_ev), .dma_set(dma_set),
    .ctrl_q(ctrl_q), .stat_q(stat_q), .dma_q(dma_q),
    .bytes_q(bytes_q), .blk_q(blk_q), .tmo_q(tmo_q)
  );

  always_comb begin
    stat_view = stat_q;
    if (data_ready) stat_view[ST_READY] = 1'b1;
    else            stat_view[ST_EMPTY] = 1'b1;
  end

  always_comb begin
    case (reg_idx)
      IX_CTRL:  reg_rdata = ctrl_q;
      IX_MASK:  reg_rdata = mask_q;
      IX_RAW:   reg_rdata = raw_q;
      IX_MSTAT: reg_rdata = raw_q & mask_q;
      IX_STAT:  reg_rdata = stat_view;
      IX_DMA:   reg_rdata = dma_q;
      IX_BYTES: reg_rdata = bytes_q;
      IX_BLK:   reg_rdata = blk_q;
      IX_TMO:   reg_rdata = tmo_q;
      IX_REM:   reg_rdata = rem_q;
      default:  reg_rdata = '0;
    endcase
  end

  // R3
  insert_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    card_insert |=> (raw_q[BIT_INS] && !raw_q[BIT_OUT]));
  // R1
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_idx == IX_CTRL && !reg_wdata[BIT_IRQ_EN]) |=> !irq);
  // R6
  done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_hit |=> raw_q[BIT_DONE]);
endmodule

// File: tb/sdhc_irq_regs_tb.sv
module sdhc_irq_regs_tb_top;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_idx = 4'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] ev_set = '0;
  logic        card_insert = 1'b0, card_remove = 1'b0;
  logic [31:0] dma_set = '0;
  logic        beat_valid = 1'b0;
  logic [7:0]  beat_bytes = '0;
  logic        data_ready = 1'b0;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  sdhc_irq_regs dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_set(ev_set),
    .card_insert(card_insert), .card_remove(card_remove), .dma_set(dma_set),
    .beat_valid(beat_valid), .beat_bytes(beat_bytes), .data_ready(data_ready),
    .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] i, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_idx = i; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [3:0] i, input logic [31:0] exp);
    @(negedge clk); reg_idx = i; #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic irqchk(input string req, input logic exp);
    @(negedge clk); #1;
    chk(req, {31'd0, irq}, {31'd0, exp});
  endtask

  task automatic pulse_ev(input logic [31:0] m);
    @(negedge clk); ev_set = m;
    @(negedge clk); ev_set = '0;
  endtask

  task automatic card(input logic ins, input logic rem);
    @(negedge clk); card_insert = ins; card_remove = rem;
    @(negedge clk); card_insert = 1'b0; card_remove = 1'b0;
  endtask

  task automatic beat(input logic [7:0] b);
    @(negedge clk); beat_valid = 1'b1; beat_bytes = b;
    @(negedge clk); beat_valid = 1'b0;
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int szs[4];
    int lens[6];
    szs = '{1, 3, 4, 7};
    lens = '{0, 1, 5, 13, 64, 100};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R7 reset values (status read includes empty bit 2 since data_ready=0, R8)
    rd("R7 ctrl", 4'd0, 32'h300);
    rd("R7 mask", 4'd1, 32'h0);
    rd("R7 raw", 4'd2, 32'h0);
    rd("R7 status", 4'd4, 32'h104);
    rd("R7 dma", 4'd5, 32'h0);
    rd("R7 bytes", 4'd6, 32'h200);
    rd("R7 blk", 4'd7, 32'h200);
    rd("R7 tmo", 4'd8, 32'hFFFFFF40);
    rd("R7 rem", 4'd9, 32'h0);
    irqchk("R7 irq", 1'b0);

    // R11 plain registers and unmapped index
    wr(4'd7, 32'h1234_5678); rd("R11 blk", 4'd7, 32'h1234_5678);
    wr(4'd8, 32'hCAFE_0001); rd("R11 tmo", 4'd8, 32'hCAFE_0001);
    wr(4'd12, 32'hFFFF_FFFF); rd("R11 unmapped", 4'd12, 32'h0);
    rd("R11 raw untouched", 4'd2, 32'h0);

    // R4 self-clearing reset bits
    wr(4'd0, 32'hFFFF_FFFF); rd("R4 ctrl", 4'd0, 32'hFFFF_FFF8);
    wr(4'd0, 32'h0000_0017); rd("R4 ctrl", 4'd0, 32'h0000_0010);

    // R1/R2 walk every raw bit
    for (int k = 0; k < 32; k++) begin
      logic [31:0] b;
      b = 32'd1 << k;
      pulse_ev(b);
      rd("R2 raw set", 4'd2, b);
      wr(4'd1, ~b);
      rd("R2 masked off", 4'd3, 32'h0);
      irqchk("R1 masked off", 1'b0);
      wr(4'd1, b);
      rd("R2 masked on", 4'd3, b);
      irqchk("R1 enabled", 1'b1);
      wr(4'd0, 32'h0);
      irqchk("R1 gated", 1'b0);
      wr(4'd0, 32'h10);
      wr((k % 2 == 0) ? 4'd2 : 4'd3, b);
      rd("R2 cleared", 4'd2, 32'h0);
      irqchk("R1 after clear", 1'b0);
    end

    // R9 set beats clear in the same cycle
    pulse_ev(32'hF0);
    @(negedge clk); reg_we = 1'b1; reg_idx = 4'd2; reg_wdata = 32'hFFFF_FFFF; ev_set = 32'h5;
    @(negedge clk); reg_we = 1'b0; ev_set = '0;
    rd("R9 raw", 4'd2, 32'h5);
    wr(4'd2, 32'hFFFF_FFFF);

    // R10 status clear, R3 card events, R8 ready view
    wr(4'd4, 32'h100); rd("R10 status clr", 4'd4, 32'h004);
    card(1'b1, 1'b0);
    rd("R3 insert raw", 4'd2, 32'h4000_0000);
    rd("R3 insert stat", 4'd4, 32'h104);
    card(1'b0, 1'b1);
    rd("R3 remove raw", 4'd2, 32'h8000_0000);
    rd("R3 remove stat", 4'd4, 32'h004);
    card(1'b1, 1'b1);
    rd("R3 both raw", 4'd2, 32'h4000_0000);
    rd("R3 both stat", 4'd4, 32'h104);
    data_ready = 1'b1;
    rd("R8 ready", 4'd4, 32'h20100);
    data_ready = 1'b0;
    rd("R8 empty", 4'd4, 32'h104);
    @(negedge clk); reg_we = 1'b1; reg_idx = 4'd4; reg_wdata = 32'h100; card_insert = 1'b1;
    @(negedge clk); reg_we = 1'b0; card_insert = 1'b0;
    rd("R10 card overrides", 4'd4, 32'h104);
    wr(4'd2, 32'hFFFF_FFFF);

    // R5 DMA status clear window
    @(negedge clk); dma_set = 32'hFFFF_FFFF;
    @(negedge clk); dma_set = '0;
    rd("R5 dma set", 4'd5, 32'hFFFF_FFFF);
    wr(4'd5, 32'hFFFF_FFFF); rd("R5 window", 4'd5, 32'hFFFF_FC00);
    @(negedge clk); dma_set = 32'h3;
    @(negedge clk); dma_set = '0;
    wr(4'd5, 32'h1); rd("R5 partial", 4'd5, 32'hFFFF_FC02);
    @(negedge clk); reg_we = 1'b1; reg_idx = 4'd5; reg_wdata = 32'h2; dma_set = 32'h2;
    @(negedge clk); reg_we = 1'b0; dma_set = '0;
    rd("R9 dma", 4'd5, 32'hFFFF_FC02);

    // R6 counter sweep
    foreach (lens[li]) begin
      foreach (szs[si]) begin
        int exp_rem;
        logic done;
        wr(4'd2, 32'hFFFF_FFFF);
        wr(4'd6, 32'(lens[li]));
        exp_rem = lens[li];
        done = 1'b0;
        rd("R6 load", 4'd9, 32'(exp_rem));
        rd("R6 bytes", 4'd6, 32'(lens[li]));
        while (!done) begin
          beat(8'(szs[si]));
          exp_rem = (exp_rem > szs[si]) ? exp_rem - szs[si] : 0;
          if (exp_rem == 0) done = 1'b1;
          rd("R6 rem", 4'd9, 32'(exp_rem));
          rd("R6 done bit", 4'd2, done ? 32'h8 : 32'h0);
        end
      end
    end
    // R6 load wins over a beat in the same cycle
    @(negedge clk); reg_we = 1'b1; reg_idx = 4'd6; reg_wdata = 32'd20; beat_valid = 1'b1; beat_bytes = 8'd4;
    @(negedge clk); reg_we = 1'b0; beat_valid = 1'b0;
    rd("R6 load priority", 4'd9, 32'd20);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule